// File: doc/BRIEF.md
# Chainable FIFO Buffer with Rewind and Token Passing

This block is a first-in first-out word buffer that is 9 bits wide. It has a power-of-two depth set by a parameter. Writing and reading use active-low strobes that are sampled on the clock. The read data drive is represented by an output-enable signal. The flags report empty, full and half-full. A rewind request replays every word stored since reset, starting from location zero, provided the write pointer has not wrapped.

A two-bit mode input selects one of three configurations:

- **Standalone (`2'b00`) and width-chained (`2'b01`):** the shared `hf_xo` output is the half-full flag, and the shared `rt_fl_n` input is the rewind request.
- **Depth-chained (`2'b10`):** several buffers share one stream. Each buffer holds separate write and read authority. A buffer passes each authority on with a one-cycle pulse on `hf_xo` after it uses its last location. The next buffer picks it up through `xin_n`. In this mode, `rt_fl_n` is a static strap that marks the buffer that holds both authorities after reset.

Top module: `fifo_chain_buf`

## Requirements
- R1: Words leave the buffer in the order they were accepted, 9 bits each, with no loss and no duplication.
- R2: A write is accepted on each clock edge where `wr_n` is low and the write is allowed. A read is accepted on the edge where `rd_n` is first seen low after being high. `rd_data` shows the read word right after that edge.
- R3: `rd_oe` is high exactly while `rd_n` is low.
- R4: A write while `full` is high is dropped. A read while `empty` is high removes nothing. `empty` and `full` are never high together.
- R5: In modes `2'b00` and `2'b01`, `hf_xo` is high exactly while the stored count is at least DEPTH/2. In mode `2'b10`, `hf_xo` carries no half-full level.
- R6: In modes `2'b00`/`2'b01`, a cycle with `rt_fl_n` low and both strobes high has two effects: later reads restart from location zero, and the count becomes the number of words written since reset. This rewind is ignored once the write pointer has wrapped since reset.
- R7: After reset, `empty`=1, `full`=0 and `hf_xo`=0.
- R8: In mode `2'b10`, write authority after reset belongs to the buffer strapped with `rt_fl_n` low. Writes without write authority are dropped. A write into the last location gives up write authority and raises `hf_xo` for one cycle. A one-cycle low on `xin_n` grants write authority to a buffer that lacks it.
- R9: In mode `2'b10`, read authority follows the same scheme. Reads without read authority are dropped. A read of the last location gives up read authority with a one-cycle `hf_xo` pulse. A `xin_n` pulse grants read authority only to a buffer that already holds write authority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 00 standalone, 01 width-chained, 10 depth-chained |
| wr_n | input | 1 | Active-low write strobe |
| wr_data | input | WIDTH | Write word |
| rd_n | input | 1 | Active-low read strobe |
| rt_fl_n | input | 1 | Rewind request (modes 00/01); first-load strap (mode 10), both active low |
| xin_n | input | 1 | Active-low authority pulse from the previous buffer in the chain |
| rd_data | output | WIDTH | Last word read |
| rd_oe | output | 1 | Data drive enable, high while reading |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| hf_xo | output | 1 | Half-full (modes 00/01) or authority pass pulse (mode 10) |

## Verification
The hardest situation to reach is the rewind refusal. It only happens after the write pointer has wrapped, so the stimulus first fills the buffer completely and drains it. It then writes two more words and requests a rewind, and must see the second word rather than a replay.

The other hard part is the depth-chained hand-off. It needs a full sweep of every location before authority moves. The stimulus therefore walks a single first-load buffer through:

- 16 writes and 16 reads;
- refused accesses in between;
- two injected `xin_n` pulses that return write authority first and read authority second.

// File: rtl/fifo_chain_pkg.sv
`timescale 1ns/1ps
package fifo_chain_pkg;
  typedef enum logic [1:0] {
    MODE_SOLO = 2'b00,
    MODE_WIDE = 2'b01,
    MODE_DEEP = 2'b10
  } fifo_mode_e;
endpackage

// File: rtl/fifo_rst_sync.sv
`timescale 1ns/1ps
module fifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = shift_q[STAGES-1];
endmodule

// File: rtl/fifo_store.sv
`timescale 1ns/1ps
module fifo_store #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cell_q [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  // array carries no reset: contents are don't-care until written
  always_ff @(posedge clk) begin
    if (we) cell_q[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= cell_q[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/fifo_token.sv
`timescale 1ns/1ps
module fifo_token (
  input  logic clk,
  input  logic rst_n,
  input  logic deep,
  input  logic first_ld,
  input  logic advance,
  input  logic grant,
  output logic auth
);
  logic flip_q, flip_d;

  // authority = strap XOR flip: reset value constant, owner set by strap
  assign auth = ~deep | (first_ld ^ flip_q);

  always_comb begin
    flip_d = flip_q;
    if (deep && ((advance && auth) || (grant && !auth))) flip_d = ~flip_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flip_q <= 1'b0;
    else        flip_q <= flip_d;
  end
endmodule

// File: rtl/fifo_ptr_ctrl.sv
`timescale 1ns/1ps
module fifo_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          rewind_req,
  input  logic          wr_auth,
  input  logic          rd_auth,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic          wr_last,
  output logic          rd_last,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic          wrapped,
  output logic          empty,
  output logic          full,
  output logic          half
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] TOP  = CW'(DEPTH);

  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap_q, wrap_d;
  logic          rdh_q;
  logic          rd_edge, rew_fire;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == TOP);
  assign half    = (cnt_q >= HALF);
  assign rd_edge = rdh_q & ~rd_n;
  assign wr_fire = ~wr_n & ~full & wr_auth;
  assign rd_fire = rd_edge & ~empty & rd_auth;
  assign wr_last = (wptr_q == LAST);
  assign rd_last = (rptr_q == LAST);
  assign rew_fire = rewind_req & wr_n & rd_n & ~wrap_q;

  always_comb begin
    wptr_d = wptr_q + AW'(wr_fire);
    wrap_d = wrap_q | (wr_fire & wr_last);
    if (rew_fire) begin
      rptr_d = '0;
      cnt_d  = {1'b0, wptr_q};
    end else begin
      rptr_d = rptr_q + AW'(rd_fire);
      cnt_d  = cnt_q + CW'(wr_fire) - CW'(rd_fire);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      wrap_q <= 1'b0;
      rdh_q  <= 1'b1;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
      rdh_q  <= rd_n;
    end
  end

  assign wptr    = wptr_q;
  assign rptr    = rptr_q;
  assign count   = cnt_q;
  assign wrapped = wrap_q;
endmodule

// File: rtl/fifo_chain_buf.sv
`timescale 1ns/1ps
module fifo_chain_buf #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             wr_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_n,
  input  logic             rt_fl_n,
  input  logic             xin_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_oe,
  output logic             empty,
  output logic             full,
  output logic             hf_xo
);
  import fifo_chain_pkg::*;

  logic          core_rst_n;
  logic          deep, first_ld, xin_hit;
  logic          wr_auth, rd_auth, wr_grant, rd_grant;
  logic          wr_fire, rd_fire, wr_last, rd_last;
  logic          wr_pass, rd_pass, half;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          wrapped;
  logic          xo_q, xo_d;

  assign deep     = (mode_sel == MODE_DEEP);
  assign first_ld = ~rt_fl_n;
  assign xin_hit  = deep & ~xin_n;
  // write authority is restored before read authority
  assign wr_grant = xin_hit & ~wr_auth;
  assign rd_grant = xin_hit & wr_auth & ~rd_auth;
  assign wr_pass  = wr_fire & wr_last;
  assign rd_pass  = rd_fire & rd_last;

  fifo_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(core_rst_n)
  );

  fifo_token u_wtok (
    .clk(clk), .rst_n(core_rst_n), .deep(deep), .first_ld(first_ld),
    .advance(wr_pass), .grant(wr_grant), .auth(wr_auth)
  );

  fifo_token u_rtok (
    .clk(clk), .rst_n(core_rst_n), .deep(deep), .first_ld(first_ld),
    .advance(rd_pass), .grant(rd_grant), .auth(rd_auth)
  );

  fifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(core_rst_n), .wr_n(wr_n), .rd_n(rd_n),
    .rewind_req(~deep & ~rt_fl_n), .wr_auth(wr_auth), .rd_auth(rd_auth),
    .wr_fire(wr_fire), .rd_fire(rd_fire), .wr_last(wr_last), .rd_last(rd_last),
    .wptr(wptr), .rptr(rptr), .count(count), .wrapped(wrapped),
    .empty(empty), .full(full), .half(half)
  );

  fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(core_rst_n), .we(wr_fire), .waddr(wptr),
    .wdata(wr_data), .re(rd_fire), .raddr(rptr), .rdata(rd_data)
  );

  assign xo_d = deep & (wr_pass | rd_pass);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) xo_q <= 1'b0;
    else             xo_q <= xo_d;
  end

  assign hf_xo = deep ? xo_q : half;
  assign rd_oe = ~rd_n;
endmodule

// File: rtl/fifo_chain_buf_chk.sv
`timescale 1ns/1ps
module fifo_chain_buf_chk #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input logic          clk,
  input logic          core_rst_n,
  input logic [1:0]    mode_sel,
  input logic          wr_n,
  input logic          rd_n,
  input logic          rt_fl_n,
  input logic          empty,
  input logic          full,
  input logic          hf_xo,
  input logic [CW-1:0] count,
  input logic [AW-1:0] rptr,
  input logic          wrapped,
  input logic          wr_auth
);
  import fifo_chain_pkg::*;

  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(empty && full));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (full && !wr_n && rd_n) |=> $stable(count));

  assert_no_underrun_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (empty && wr_n && (rt_fl_n || mode_sel == MODE_DEEP)) |=> empty);

  assert_hf_rise_cause_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (mode_sel != MODE_DEEP && $past(mode_sel) != MODE_DEEP && $rose(hf_xo))
      |-> $past(!wr_n || !rt_fl_n));

  assert_rewind_zero_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    ($past(mode_sel) != MODE_DEEP && $past(!rt_fl_n && wr_n && rd_n && !wrapped))
      |-> (rptr == '0));

  assert_no_write_without_token_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (mode_sel == MODE_DEEP && !wr_auth && rd_n) |=> $stable(count));
endmodule

bind fifo_chain_buf fifo_chain_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .core_rst_n(core_rst_n), .mode_sel(mode_sel), .wr_n(wr_n),
  .rd_n(rd_n), .rt_fl_n(rt_fl_n), .empty(empty), .full(full), .hf_xo(hf_xo),
  .count(count), .rptr(rptr), .wrapped(wrapped), .wr_auth(wr_auth)
);

// File: tb/tb_fifo_chain_buf.sv
`timescale 1ns/1ps
module tb_fifo_chain_buf;
  localparam int W = 9;
  localparam int D = 16;

  logic         clk = 1'b0;
  logic         rst_n, wr_n, rd_n, rt_fl_n, xin_n;
  logic [1:0]   mode_sel;
  logic [W-1:0] wr_data, rd_data;
  logic         rd_oe, empty, full, hf_xo;

  int n_chk = 0;
  int n_bad = 0;
  bit sb_on = 1'b0;
  bit prev_rd = 1'b1;
  bit rd_seen;
  logic [W-1:0] exp_word;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] hist[$];
  int  wptr_m;
  bit  wrap_m;

  always #2.5 clk = ~clk;

  fifo_chain_buf #(.WIDTH(W), .DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wr_n(wr_n),
    .wr_data(wr_data), .rd_n(rd_n), .rt_fl_n(rt_fl_n), .xin_n(xin_n),
    .rd_data(rd_data), .rd_oe(rd_oe), .empty(empty), .full(full),
    .hf_xo(hf_xo)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // monitor: pops the scoreboard on each accepted read edge
  always @(posedge clk) begin
    rd_seen = prev_rd && !rd_n;
    prev_rd = rd_n;
    if (sb_on && rd_seen && exp_q.size() > 0) begin
      exp_word = exp_q.pop_front();
      #1;
      check_eq("R1", "read order", int'(rd_data), int'(exp_word));
    end
  end

  task automatic do_reset(logic [1:0] m, logic fl);
    rst_n = 1'b0; mode_sel = m; rt_fl_n = fl;
    wr_n = 1'b1; rd_n = 1'b1; xin_n = 1'b1; wr_data = '0;
    exp_q.delete(); hist.delete(); wptr_m = 0; wrap_m = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  // driver: pushes the expected word when the model accepts it
  task automatic do_write(logic [W-1:0] v);
    wr_data = v; wr_n = 1'b0;
    tick();
    wr_n = 1'b1;
    if (exp_q.size() < D) begin
      exp_q.push_back(v);
      hist.push_back(v);
      wptr_m = (wptr_m + 1) % D;
      if (wptr_m == 0) wrap_m = 1'b1;
    end
  endtask

  task automatic do_read();
    rd_n = 1'b0;
    tick();
    check_eq("R3", "rd_oe while reading", int'(rd_oe), 1);
    rd_n = 1'b1;
    tick();
  endtask

  task automatic do_rewind();
    rt_fl_n = 1'b0;
    tick();
    rt_fl_n = 1'b1;
    if (!wrap_m) exp_q = hist;
    tick();
  endtask

  task automatic pulse_xin();
    xin_n = 1'b0;
    tick();
    xin_n = 1'b1;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    // standalone
    do_reset(2'b00, 1'b1);
    sb_on = 1'b1;
    check_eq("R7", "empty after reset", int'(empty), 1);
    check_eq("R7", "full after reset", int'(full), 0);
    check_eq("R7", "hf after reset", int'(hf_xo), 0);
    check_eq("R3", "rd_oe idle", int'(rd_oe), 0);

    // R1 R2: basic order
    do_write(9'h011); do_write(9'h022); do_write(9'h033);
    check_eq("R2", "not empty after writes", int'(empty), 0);
    repeat (3) do_read();
    check_eq("R2", "empty after draining", int'(empty), 1);

    // R4: read while empty removes nothing
    do_read();
    check_eq("R4", "empty after read on empty", int'(empty), 1);
    do_write(9'h155);
    do_read();

    // R6: rewind replays 4 words
    do_rewind();
    check_eq("R6", "not empty after rewind", int'(empty), 0);
    repeat (4) do_read();
    check_eq("R6", "empty after replay", int'(empty), 1);

    // R5 in width-chained mode, fill to full
    mode_sel = 2'b01;
    for (int i = 0; i < 7; i++) do_write(W'(9'h100 + i));
    check_eq("R5", "hf below half", int'(hf_xo), 0);
    do_write(9'h107);
    check_eq("R5", "hf at half", int'(hf_xo), 1);
    for (int i = 8; i < 16; i++) do_write(W'(9'h100 + i));
    check_eq("R4", "full at depth", int'(full), 1);
    do_write(9'h1FF);
    check_eq("R4", "full after blocked write", int'(full), 1);
    repeat (8) do_read();
    check_eq("R5", "hf at count 8", int'(hf_xo), 1);
    do_read();
    check_eq("R5", "hf at count 7", int'(hf_xo), 0);
    repeat (7) do_read();
    check_eq("R4", "empty after full drain", int'(empty), 1);

    // R6: rewind ignored after wrap
    do_write(9'h0AA); do_write(9'h0BB);
    do_read();
    do_rewind();
    do_read();
    check_eq("R6", "empty after ignored rewind", int'(empty), 1);

    // depth-chained, first-load buffer
    sb_on = 1'b0;
    do_reset(2'b10, 1'b0);
    for (int i = 0; i < 8; i++) do_write(W'(i));
    check_eq("R5", "no hf level in depth mode", int'(hf_xo), 0);
    for (int i = 8; i < 15; i++) do_write(W'(i));
    wr_data = 9'd15; wr_n = 1'b0;
    tick();
    wr_n = 1'b1;
    check_eq("R8", "pass pulse on last write", int'(hf_xo), 1);
    tick();
    check_eq("R8", "pass pulse one cycle", int'(hf_xo), 0);
    check_eq("R8", "full after 16", int'(full), 1);
    rd_n = 1'b0;
    tick();
    check_eq("R9", "first word read", int'(rd_data), 0);
    rd_n = 1'b1;
    tick();
    do_write(9'h1EE);
    check_eq("R8", "write dropped without authority", int'(full), 0);
    for (int i = 1; i < 15; i++) begin
      rd_n = 1'b0; tick(); rd_n = 1'b1; tick();
    end
    rd_n = 1'b0;
    tick();
    check_eq("R9", "last word read", int'(rd_data), 15);
    check_eq("R9", "pass pulse on last read", int'(hf_xo), 1);
    rd_n = 1'b1;
    tick();
    check_eq("R9", "empty after sweep", int'(empty), 1);
    do_write(9'h1DD);
    check_eq("R8", "write dropped after pass", int'(empty), 1);
    pulse_xin();
    do_write(9'h077);
    check_eq("R8", "write after grant", int'(empty), 0);
    rd_n = 1'b0; tick(); rd_n = 1'b1; tick();
    check_eq("R9", "read dropped without authority", int'(empty), 0);
    pulse_xin();
    rd_n = 1'b0;
    tick();
    check_eq("R9", "read after grant", int'(rd_data), 9'h077);
    rd_n = 1'b1;
    tick();
    check_eq("R9", "empty after granted read", int'(empty), 1);

    // depth-chained, not first-load
    do_reset(2'b10, 1'b1);
    do_write(9'h0CC);
    check_eq("R8", "no authority at reset", int'(empty), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule